// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a 32-bit load/store processor that reuses a single ALU and a single memory port across several clock cycles per instruction. It reads the 6-bit opcode held in the instruction register and steps through a ten-state graph. Every instruction first passes through a common fetch state and a common decode state. The graph then splits into one short path per instruction class. Each class therefore takes a fixed number of cycles: load 5, store 4, register-type 4, branch 3 and jump 3.

All control outputs are Moore outputs and depend only on the current state. A state drives only the strobes and selects it needs. Everything else is deasserted, so no write strobe carries over from one state into the next. Values that must survive from one cycle to the next are assumed to sit in held datapath registers: the instruction register, the A/B operand registers, the ALU output register and the memory data register. The datapath itself is outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is low, and in the first cycle after it, the block is in fetch. Fetch drives mem_rd=1, mem_addr_sel=0 (PC), ir_wr=1, pc_wr=1, alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_op=0 (add) and pc_src=0 (ALU result, i.e. PC+4). The cycle after fetch is always decode.
- R2: Decode drives alu_a_sel=0, alu_b_sel=3 (shifted immediate) and alu_op=0, with every write strobe low. The next state comes from the opcode: 6'h23 is load, 6'h2B is store, 6'h00 is register-type, 6'h04 is branch and 6'h02 is jump.
- R3: A load takes 5 cycles. After decode comes address compute (alu_a_sel=1, alu_b_sel=2, add). Then memory read (mem_rd=1, mem_addr_sel=1). Then write-back (rf_wr=1, wb_sel=1 for the memory data register, dst_sel=0 for the bits 20-16 field).
- R4: A store takes 4 cycles. After decode comes address compute, then memory write (mem_wr=1, mem_addr_sel=1), then the return to fetch.
- R5: A register-type instruction takes 4 cycles. After decode comes execute (alu_a_sel=1, alu_b_sel=0, alu_op=2 for the function field). Then write-back (rf_wr=1, wb_sel=0 for the ALU output register, dst_sel=1 for the bits 15-11 field).
- R6: A branch takes 3 cycles. Its final state drives pc_wr_cond=1, alu_a_sel=1, alu_b_sel=0, alu_op=1 (subtract) and pc_src=1 (ALU output register).
- R7: A jump takes 3 cycles. Its final state drives pc_wr=1 and pc_src=2 (PC[31:28] joined with the 26-bit target shifted left by 2).
- R8: Any other opcode seen in decode sends the block back to fetch. The illegal output is then high for exactly that one fetch cycle. No register-file or memory write takes place during that instruction.
- R9: At most one of mem_wr, rf_wr, pc_wr_cond and ir_wr is high in any cycle. Every path ends by returning to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| rf_wr | output | 1 | Register file write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU operand B: 0 B register, 1 constant 4, 2 sign-extended immediate, 3 immediate shifted by 2 |
| alu_op | output | 2 | ALU function: 0 add, 1 subtract, 2 function field |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| dst_sel | output | 1 | Destination register field: 0 bits 20-16, 1 bits 15-11 |
| illegal | output | 1 | One-cycle pulse after an unknown opcode is seen in decode |

## Verification
The assertions assume that the opcode input is stable from decode to the end of the instruction, as it is when the instruction register is written only in fetch. The bench changes the opcode only while the block is in fetch, and it holds that value until the next fetch. The assertions also assume that reset is applied for at least one clock edge before checking begins. The bench holds reset low for several cycles at the start, and it asserts reset again in the middle of an instruction to show that the block returns to fetch.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared types for the multicycle control sequencer.
// Holds the state encoding, the instruction-class encoding and the
// packed control bundle that the output decoder emits.
package mc_ctrl_pkg;

    localparam int OPW = 6;

    typedef enum logic [3:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_MADDR  = 4'd2,
        S_MREAD  = 4'd3,
        S_LDWB   = 4'd4,
        S_MWRITE = 4'd5,
        S_EXEC   = 4'd6,
        S_RWB    = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9
    } state_e;

    typedef enum logic [2:0] {
        C_LOAD   = 3'd0,
        C_STORE  = 3'd1,
        C_RTYPE  = 3'd2,
        C_BRANCH = 3'd3,
        C_JUMP   = 3'd4,
        C_BAD    = 3'd5
    } op_class_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       rf_wr;
        logic       mem_addr_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic [1:0] pc_src;
        logic       wb_sel;
        logic       dst_sel;
    } ctrl_t;

endpackage

// File: rtl/mc_ctrl_opclass.sv
// Opcode classifier: maps the raw opcode to an instruction class.
// Assumes opcode is stable while the sequencer is in decode or later states.
module mc_ctrl_opclass
    import mc_ctrl_pkg::*;
#(
    parameter int            W       = 6,
    parameter logic [W-1:0]  OP_LOAD = 6'h23,
    parameter logic [W-1:0]  OP_STOR = 6'h2B,
    parameter logic [W-1:0]  OP_RTYP = 6'h00,
    parameter logic [W-1:0]  OP_BRCH = 6'h04,
    parameter logic [W-1:0]  OP_JUMP = 6'h02
) (
    input  logic [W-1:0] opcode,
    output op_class_e    cls
);

    // Compare the opcode against each class code; unknown codes map to C_BAD.
    always_comb begin
        if (opcode == OP_LOAD)      cls = C_LOAD;
        else if (opcode == OP_STOR) cls = C_STORE;
        else if (opcode == OP_RTYP) cls = C_RTYPE;
        else if (opcode == OP_BRCH) cls = C_BRANCH;
        else if (opcode == OP_JUMP) cls = C_JUMP;
        else                        cls = C_BAD;
    end

endmodule

// File: rtl/mc_ctrl_next.sv
// Next-state logic: fetch always goes to decode, decode fans out by class,
// address compute splits load from store, and every final state
// returns to fetch.
// Also flags an unknown class seen in decode.
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_e    state,
    input  op_class_e cls,
    output state_e    nxt,
    output logic      bad_op
);

    // Compute the successor state from the present state and instruction class.
    always_comb begin
        nxt    = S_FETCH;
        bad_op = 1'b0;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    C_LOAD, C_STORE: nxt = S_MADDR;
                    C_RTYPE:         nxt = S_EXEC;
                    C_BRANCH:        nxt = S_BRANCH;
                    C_JUMP:          nxt = S_JUMP;
                    default: begin
                        nxt    = S_FETCH;
                        bad_op = 1'b1;
                    end
                endcase
            end
            S_MADDR:  nxt = (cls == C_LOAD) ? S_MREAD : S_MWRITE;
            S_MREAD:  nxt = S_LDWB;
            S_EXEC:   nxt = S_RWB;
            default:  nxt = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_outdec.sv
// Moore output decoder: turns the present state into the control bundle.
// Every field starts from zero and each state sets only what it needs,
// so no strobe persists across states.
module mc_ctrl_outdec
    import mc_ctrl_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    // Drive the per-state control fields over an all-zero default.
    always_comb begin
        ctrl = '0;
        unique case (state)
            S_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.alu_b_sel = 2'd1;
            end
            S_DECODE: ctrl.alu_b_sel = 2'd3;
            S_MADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = 2'd2;
            end
            S_MREAD: begin
                ctrl.mem_rd       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            S_LDWB: begin
                ctrl.rf_wr  = 1'b1;
                ctrl.wb_sel = 1'b1;
            end
            S_MWRITE: begin
                ctrl.mem_wr       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            S_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_op    = 2'd2;
            end
            S_RWB: begin
                ctrl.rf_wr   = 1'b1;
                ctrl.dst_sel = 1'b1;
            end
            S_BRANCH: begin
                ctrl.pc_wr_cond = 1'b1;
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_op     = 2'd1;
                ctrl.pc_src     = 2'd1;
            end
            S_JUMP: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_src = 2'd2;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Top: multicycle processor control sequencer.
// Holds the state register and the illegal-opcode pulse register, and
// wires the classifier, next-state logic and output decoder together.
// Assumes opcode comes from the instruction register written in fetch.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int            W       = OPW,
    parameter logic [W-1:0]  OP_LOAD = 6'h23,
    parameter logic [W-1:0]  OP_STOR = 6'h2B,
    parameter logic [W-1:0]  OP_RTYP = 6'h00,
    parameter logic [W-1:0]  OP_BRCH = 6'h04,
    parameter logic [W-1:0]  OP_JUMP = 6'h02
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opcode,
    output logic         pc_wr,
    output logic         pc_wr_cond,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         ir_wr,
    output logic         rf_wr,
    output logic         mem_addr_sel,
    output logic         alu_a_sel,
    output logic [1:0]   alu_b_sel,
    output logic [1:0]   alu_op,
    output logic [1:0]   pc_src,
    output logic         wb_sel,
    output logic         dst_sel,
    output logic         illegal
);

    state_e    state_q;
    state_e    state_d;
    op_class_e cls;
    logic      bad_op;
    logic      illegal_q;
    ctrl_t     ctrl;

    mc_ctrl_opclass #(
        .W(W), .OP_LOAD(OP_LOAD), .OP_STOR(OP_STOR), .OP_RTYP(OP_RTYP),
        .OP_BRCH(OP_BRCH), .OP_JUMP(OP_JUMP)
    ) u_cls (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_ctrl_next u_next (
        .state  (state_q),
        .cls    (cls),
        .nxt    (state_d),
        .bad_op (bad_op)
    );

    mc_ctrl_outdec u_dec (
        .state (state_q),
        .ctrl  (ctrl)
    );

    // State register, synchronous active-low reset into fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // Illegal-opcode pulse, high during the fetch that follows a bad decode.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= bad_op;
    end

    // Break the control bundle out onto the port list.
    always_comb begin
        pc_wr        = ctrl.pc_wr;
        pc_wr_cond   = ctrl.pc_wr_cond;
        mem_rd       = ctrl.mem_rd;
        mem_wr       = ctrl.mem_wr;
        ir_wr        = ctrl.ir_wr;
        rf_wr        = ctrl.rf_wr;
        mem_addr_sel = ctrl.mem_addr_sel;
        alu_a_sel    = ctrl.alu_a_sel;
        alu_b_sel    = ctrl.alu_b_sel;
        alu_op       = ctrl.alu_op;
        pc_src       = ctrl.pc_src;
        wb_sel       = ctrl.wb_sel;
        dst_sel      = ctrl.dst_sel;
        illegal      = illegal_q;
    end

endmodule

// File: rtl/mc_ctrl_chk.sv
// Checker: temporal properties on the sequencer's ports, bound to the top.
// Assumes opcode holds steady from fetch to the end of each instruction.
module mc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       rf_wr,
    input logic       mem_addr_sel,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_op,
    input logic [1:0] pc_src,
    input logic       wb_sel,
    input logic       dst_sel,
    input logic       illegal
);

    // R1: fetch is followed by decode.
    p_fetch_then_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (!ir_wr && alu_b_sel == 2'd3 && !alu_a_sel));

    // R3: a memory-data write-back follows a memory read through the ALU output register.
    p_load_wb_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && wb_sel) |-> $past(mem_rd && mem_addr_sel));

    // R4: a memory write follows the address compute step.
    p_store_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(alu_a_sel && alu_b_sel == 2'd2));

    // R5: an ALU-result write-back follows the execute step.
    p_rtype_wb_after_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && !wb_sel) |-> $past(alu_op == 2'd2));

    // R8: the illegal flag lasts one cycle and coincides with fetch.
    p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (ir_wr && !rf_wr && !mem_wr) ##1 !illegal);

    // R9: at most one write strobe per cycle.
    p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, rf_wr, pc_wr_cond, ir_wr}));

    // R9: every final state hands back to fetch.
    p_back_to_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == 2'd2)) |=> ir_wr);

endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_wr        (pc_wr),
    .pc_wr_cond   (pc_wr_cond),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .ir_wr        (ir_wr),
    .rf_wr        (rf_wr),
    .mem_addr_sel (mem_addr_sel),
    .alu_a_sel    (alu_a_sel),
    .alu_b_sel    (alu_b_sel),
    .alu_op       (alu_op),
    .pc_src       (pc_src),
    .wb_sel       (wb_sel),
    .dst_sel      (dst_sel),
    .illegal      (illegal)
);

// File: tb/test_mc_ctrl_fsm.sv
// Bench for the control sequencer: table-driven instruction walk, then
// directed checks for reset, illegal opcodes and per-class cycle counts.
module test_mc_ctrl_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, rf_wr;
    logic       mem_addr_sel, alu_a_sel, wb_sel, dst_sel, illegal;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] LD = 6'h23, ST = 6'h2B, RT = 6'h00, BR = 6'h04, JP = 6'h02;
    localparam logic [15:0] V_FETCH = 16'hA840;
    localparam logic [15:0] V_DEC   = 16'h00C0;

    // {opcode, expected control vector}, one row per cycle.
    localparam int NROW = 19;
    localparam logic [21:0] TBL [NROW] = '{
        {LD, 16'hA840}, {LD, 16'h00C0}, {LD, 16'h0180}, {LD, 16'h2200}, {LD, 16'h0402},
        {ST, 16'hA840}, {ST, 16'h00C0}, {ST, 16'h0180}, {ST, 16'h1200},
        {RT, 16'hA840}, {RT, 16'h00C0}, {RT, 16'h0120}, {RT, 16'h0401},
        {BR, 16'hA840}, {BR, 16'h00C0}, {BR, 16'h4114},
        {JP, 16'hA840}, {JP, 16'h00C0}, {JP, 16'h8008}
    };

    mc_ctrl_fsm i_mc_ctrl_fsm (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .rf_wr(rf_wr), .mem_addr_sel(mem_addr_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .wb_sel(wb_sel), .dst_sel(dst_sel), .illegal(illegal)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] vec();
        return {pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, rf_wr, mem_addr_sel,
                alu_a_sel, alu_b_sel, alu_op, pc_src, wb_sel, dst_sel};
    endfunction

    function automatic string req_of(logic [5:0] op);
        case (op)
            LD: return "R3";
            ST: return "R4";
            RT: return "R5";
            BR: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Count cycles from one fetch to the next for the given opcode.
    task automatic count_cycles(logic [5:0] op, int exp, string req);
        int n = 0;
        opcode = op;
        do begin
            @(negedge clk);
            n++;
        end while (!ir_wr && n < 20);
        chk(req, n, exp);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state shows the fetch vector, no illegal flag.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", vec(), V_FETCH);
        chk("R1", illegal, 1'b0);
        rst_n = 1'b1;

        // Table walk: each instruction class back to back.
        for (int i = 0; i < NROW; i++) begin
            opcode = TBL[i][21:16];
            #1;
            if (TBL[i][15:0] == V_FETCH)    chk("R1", vec(), TBL[i][15:0]);
            else if (TBL[i][15:0] == V_DEC) chk("R2", vec(), TBL[i][15:0]);
            else                            chk(req_of(TBL[i][21:16]), vec(), TBL[i][15:0]);
            chk("R8", illegal, 1'b0);
            @(negedge clk);
        end

        // Per-class cycle counts, starting from fetch.
        chk("R9", ir_wr, 1'b1);
        count_cycles(LD, 5, "R3");
        count_cycles(ST, 4, "R4");
        count_cycles(RT, 4, "R5");
        count_cycles(BR, 3, "R6");
        count_cycles(JP, 3, "R7");

        // R8: unknown opcode returns to fetch with a single illegal pulse.
        opcode = 6'h3F;
        @(negedge clk);
        chk("R8", vec(), V_DEC);
        @(negedge clk);
        chk("R8", vec(), V_FETCH);
        chk("R8", illegal, 1'b1);
        chk("R8", {rf_wr, mem_wr}, 2'b00);
        opcode = RT;
        @(negedge clk);
        chk("R8", illegal, 1'b0);
        chk("R2", vec(), V_DEC);

        // R1: reset in the middle of an instruction returns to fetch.
        @(negedge clk);
        chk("R5", vec(), 16'h0120);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", vec(), V_FETCH);
        rst_n = 1'b1;
        opcode = JP;
        @(negedge clk);
        chk("R1", vec(), V_DEC);
        @(negedge clk);
        chk("R7", vec(), 16'h8008);
        @(negedge clk);
        chk("R9", vec(), V_FETCH);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule